// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a parallel port of general-purpose pins and raises an interrupt request whenever the pins differ from a stored reference image. Each pin is first passed through a synchronizer. The synchronized value is then compared with a snapshot register, and the interrupt output is registered. The output is an active-high enable that tells an open-drain pad to pull the shared interrupt line low.

A serial-bus bridge clears and re-arms the interrupt. It supplies two single-cycle pulses that mark rising and falling edges of the serial clock. It also supplies two level strobes that are high only while the acknowledge bit of a transfer addressed to this device is in progress: one for reads and one for writes.

- **Read acknowledge:** the re-arm takes effect on the serial-clock rising edge.
- **Write acknowledge:** the re-arm takes effect on the serial-clock falling edge.

At a re-arm, the snapshot takes the present synchronized pin value and the request drops. The request also drops by itself when the pins go back to the snapshot value.

Top module: `port_change_irq`

## Requirements
- R1: Reset sets the interrupt output low. It also sets the snapshot and every synchronizer stage to all ones, so pins held at all ones after reset raise no interrupt, while pins held at 0x00 do raise one.
- R2: A change in either direction on any pin asserts `irq_drive_low_o`. A pin value applied before clock edge N appears at the output after edge N+2: two synchronizer edges, then one output edge.
- R3: When the synchronized pins return to the snapshot value without any re-arm, the output deasserts with the same latency as R2.
- R4: A re-arm occurs at a clock edge where `ack_rd_i` and `scl_rise_i` are both high. At that edge the output goes low and the snapshot loads the synchronized pins. With `ack_rd_i` high, `scl_fall_i` alone does nothing.
- R5: A re-arm also occurs at a clock edge where `ack_wr_i` and `scl_fall_i` are both high, with the same effect as R4. With `ack_wr_i` high, `scl_rise_i` alone does nothing.
- R6: Serial-clock edge pulses with neither acknowledge strobe high leave both the snapshot and the output unchanged. This covers traffic addressed to other devices.
- R7: A pin change made after a re-arm is detected against the new snapshot, with the latency of R2.
- R8: A pin change whose synchronized value reaches the comparator at the same edge as a re-arm is absorbed into the snapshot. It raises no interrupt.
- R9: The output stays asserted through further pin changes for as long as the pins still differ from the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | WIDTH | Raw port pin levels, asynchronous |
| scl_rise_i | input | 1 | One-cycle pulse on a serial-clock rising edge |
| scl_fall_i | input | 1 | One-cycle pulse on a serial-clock falling edge |
| ack_rd_i | input | 1 | High during the acknowledge bit of a read addressed to this device |
| ack_wr_i | input | 1 | High during the acknowledge bit of a write addressed to this device |
| irq_drive_low_o | output | 1 | High means pull the interrupt line low |

## Verification
The main pattern set does three things:
- It moves single bits low and high, and moves whole bytes, against a snapshot of all ones and against a snapshot holding a zero bit. This separates rising-edge from falling-edge detection and separates a level request from a one-shot request.
- It pairs each acknowledge strobe with the correct serial-clock edge and with the wrong one. This shows whether the clear point depends on the transfer direction.
- It sends bare clock edges with no strobe. This shows that foreign traffic is ignored.

Directed tests measure the exact latency from a pin change to the output. They make a change meet a re-arm in the same cycle, and they reset the block with the request asserted.

// File: rtl/pcig_pkg.sv
package pcig_pkg;

  // Re-arm decision: a read acknowledge takes the rising serial-clock edge,
  // a write acknowledge takes the falling one.
  function automatic logic rearm_hit(input logic ack_rd, input logic ack_wr,
                                     input logic rise, input logic fall);
    return (ack_rd && rise) || (ack_wr && fall);
  endfunction

endpackage

// File: rtl/pcig_sync.sv
module pcig_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '1;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcig_rearm.sv
module pcig_rearm (
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  input  logic ack_rd_i,
  input  logic ack_wr_i,
  output logic rearm_o
);
  import pcig_pkg::*;

  always_comb rearm_o = rearm_hit(ack_rd_i, ack_wr_i, scl_rise_i, scl_fall_i);
endmodule

// File: rtl/pcig_track.sv
module pcig_track #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_s_i,
  input  logic             rearm_i,
  output logic             irq_o
);
  logic [WIDTH-1:0] snap_q;
  logic             irq_q;

  function automatic logic port_differs(input logic [WIDTH-1:0] now,
                                        input logic [WIDTH-1:0] ref_v);
    return |(now ^ ref_v);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '1;
      irq_q  <= 1'b0;
    end else if (rearm_i) begin
      snap_q <= pin_s_i;
      irq_q  <= 1'b0;
    end else begin
      irq_q  <= port_differs(pin_s_i, snap_q);
    end
  end

  assign irq_o = irq_q;

  // R4 and R5: a re-arm leaves the request low on the following cycle
  assert_rearm_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> !irq_q);
  // R8: the snapshot takes the pin value seen at the re-arm edge
  assert_snap_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> (snap_q == $past(pin_s_i)));
  // R6: without a re-arm the reference never moves
  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rearm_i |=> $stable(snap_q));
  // R2: a mismatch raises the request one edge later
  assert_detect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rearm_i && (pin_s_i != snap_q)) |=> irq_q);
  // R3: a match drops the request one edge later
  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rearm_i && (pin_s_i == snap_q)) |=> !irq_q);
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             ack_rd_i,
  input  logic             ack_wr_i,
  output logic             irq_drive_low_o
);
  logic [WIDTH-1:0] pin_s;
  logic             rearm;

  pcig_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  pcig_rearm u_rearm (
    .scl_rise_i(scl_rise_i), .scl_fall_i(scl_fall_i),
    .ack_rd_i(ack_rd_i), .ack_wr_i(ack_wr_i), .rearm_o(rearm)
  );

  pcig_track #(.WIDTH(WIDTH)) u_track (
    .clk(clk), .rst_n(rst_n), .pin_s_i(pin_s), .rearm_i(rearm),
    .irq_o(irq_drive_low_o)
  );

  // R6: bare clock edges with no acknowledge strobe never cause a re-arm
  assert_no_foreign_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_rd_i && !ack_wr_i) |-> !rearm);
endmodule

// File: tb/port_change_irq_tb.sv
module port_change_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = 8'hFF;
  logic       scl_rise_i = 1'b0, scl_fall_i = 1'b0;
  logic       ack_rd_i = 1'b0, ack_wr_i = 1'b0;
  logic       irq_drive_low_o;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  port_change_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .scl_rise_i(scl_rise_i),
    .scl_fall_i(scl_fall_i), .ack_rd_i(ack_rd_i), .ack_wr_i(ack_wr_i),
    .irq_drive_low_o(irq_drive_low_o)
  );

  // Entry layout: {req[3:0], exp, fall, rise, wr, rd, pins[7:0]}
  localparam int NV = 16;
  localparam logic [16:0] VEC [NV] = '{
    {4'd1, 1'b0, 4'b0000, 8'hFF},  // R1: idle, no request
    {4'd2, 1'b1, 4'b0000, 8'hFE},  // R2: bit0 falls
    {4'd3, 1'b0, 4'b0000, 8'hFF},  // R3: back to snapshot
    {4'd2, 1'b1, 4'b0000, 8'h7F},  // R2: bit7 falls
    {4'd4, 1'b1, 4'b1001, 8'h7F},  // R4: read ack on the falling edge does nothing
    {4'd4, 1'b0, 4'b0101, 8'h7F},  // R4: read ack on the rising edge re-arms
    {4'd2, 1'b1, 4'b0000, 8'hFF},  // R2: bit7 rises
    {4'd6, 1'b1, 4'b0100, 8'hFF},  // R6: bare rising edge
    {4'd6, 1'b1, 4'b1000, 8'hFF},  // R6: bare falling edge
    {4'd5, 1'b1, 4'b0110, 8'hFF},  // R5: write ack on the rising edge does nothing
    {4'd5, 1'b0, 4'b1010, 8'hFF},  // R5: write ack on the falling edge re-arms
    {4'd7, 1'b1, 4'b0000, 8'h00},  // R7: whole byte falls
    {4'd9, 1'b1, 4'b0000, 8'h0F},  // R9: still differs
    {4'd3, 1'b0, 4'b0000, 8'hFF},  // R3: return
    {4'd7, 1'b1, 4'b1010, 8'h5A},  // R7: change right after a re-arm
    {4'd3, 1'b0, 4'b0000, 8'hFF}   // R3: return to the new snapshot
  };

  function automatic string rname(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";
      4: return "R4";  5: return "R5";  6: return "R6";
      7: return "R7";  8: return "R8";  default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic exp, input string what);
    checks++;
    if (irq_drive_low_o !== exp) begin
      failures++;
      $display("FAIL %s %s: irq=%b expected=%b", req, what, irq_drive_low_o, exp);
    end
  endtask

  task automatic step(input logic [7:0] p, input logic [3:0] s);
    @(negedge clk);
    pin_i = p;
    {scl_fall_i, scl_rise_i, ack_wr_i, ack_rd_i} = s;
    @(posedge clk);
    @(negedge clk);
    {scl_fall_i, scl_rise_i, ack_wr_i, ack_rd_i} = 4'b0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 1'b0, "during reset");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", 1'b0, "after reset, pins all ones");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][7:0], VEC[i][11:8]);
      check(rname(int'(VEC[i][16:13])), VEC[i][12], $sformatf("vector %0d", i));
    end

    // R2: exact latency, the output rises on the third edge
    @(negedge clk); pin_i = 8'hEF;
    @(posedge clk); @(negedge clk); check("R2", 1'b0, "latency edge 1");
    @(posedge clk); @(negedge clk); check("R2", 1'b0, "latency edge 2");
    @(posedge clk); @(negedge clk); check("R2", 1'b1, "latency edge 3");
    @(negedge clk); pin_i = 8'hFF;
    repeat (3) @(posedge clk); @(negedge clk);
    check("R3", 1'b0, "release latency");

    // R8: the synchronized change meets a read re-arm at the same edge
    @(negedge clk); pin_i = 8'h00;
    @(posedge clk); @(posedge clk); @(negedge clk);
    ack_rd_i = 1'b1; scl_rise_i = 1'b1;
    @(posedge clk); @(negedge clk);
    ack_rd_i = 1'b0; scl_rise_i = 1'b0;
    check("R8", 1'b0, "change absorbed at re-arm");
    repeat (3) @(posedge clk); @(negedge clk);
    check("R8", 1'b0, "stays low after absorption");
    @(negedge clk); pin_i = 8'hFF;
    repeat (3) @(posedge clk); @(negedge clk);
    check("R7", 1'b1, "snapshot now 0x00");

    // R1: reset with the request asserted restores an all-ones snapshot
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1", 1'b0, "reset clears request");
    rst_n = 1'b1;
    repeat (4) @(posedge clk); @(negedge clk);
    check("R1", 1'b0, "snapshot all ones after reset");
    @(negedge clk); pin_i = 8'h00;
    repeat (3) @(posedge clk); @(negedge clk);
    check("R1", 1'b1, "0x00 differs from reset snapshot");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule